// File: doc/BRIEF.md
# Multi-Bank Operation Mode Arbiter

This block keeps the operating mode of every bank in a banked, flash-style memory controller. Each bank is in normal read mode, busy running an embedded program or erase algorithm, or showing an overlay region in place of one of its sectors. Only one bank in the whole device may be busy or overlaid at any time. The block takes decoded command requests, each tagged with a bank number, and checks them against that rule. A request it accepts changes the stored modes. A request it turns down leaves every piece of state as it was. In both cases it raises a one-cycle accept or reject pulse.

The block also classifies every host read strobe by bank and sector. A read gets one of four codes: plain array data, algorithm status, overlay data, or unavailable. The array path uses this code to pick its data source. Because only the one busy bank is blocked, reads to the other banks go on while a program or erase runs.

A program aimed at the overlaid sector moves the overlay bank into busy mode until the algorithm finishes. After that the bank goes back to showing the overlay. Programs that hit the read-only identification or factory part of the overlay are turned down and flagged as failed. A suspend request parks a running algorithm. The bank returns to read mode while the algorithm waits, which frees the device for an overlay session, and a resume request restarts the algorithm later.

Top module: `bank_mode_arbiter`

## Requirements
- R1: After reset every bank is in read mode, `susp_o` is 0 and neither `cmd_accept` nor `cmd_reject` is high. Bank b's mode is on `bank_mode_o[2b+1:2b]`, with the encoding 00 = read, 01 = busy, 10 = overlay.
- R2: At most one bank reports a mode other than read at any time.
- R3: An enter-algorithm or enter-overlay request is rejected when any bank is not in read mode. An enter-algorithm request is also rejected while an algorithm is suspended. A rejected request changes no mode.
- R4: A reset command is always accepted. It returns every bank to read mode and clears the suspended flag.
- R5: An algorithm-done request on a busy bank returns that bank to read mode. If the algorithm was an overlay program, the bank returns to overlay mode instead. On a bank that is not busy, the request is rejected.
- R6: A read of a busy bank is classified 01 (status) when `rd_status` is high and 11 (unavailable) otherwise.
- R7: A read of any bank in read mode, or of a bank in overlay mode outside its overlaid sector, is classified 00 (array).
- R8: Entering an overlay records the sector given with the request. A read of that sector in the overlay bank is classified 10 (overlay). An exit-overlay request returns the bank to read mode.
- R9: An overlay program is accepted only on the overlay bank and only for its overlaid sector. If its offset is below `RO_LIMIT`, it is rejected and `prog_fail` pulses together with `cmd_reject`. Otherwise the bank becomes busy.
- R10: A suspend request on a bank busy with a plain algorithm returns that bank to read mode and sets `susp_o`. A resume request is accepted only for the suspended bank and only while all banks are in read mode. It makes the bank busy again and clears `susp_o`.
- R11: Command codes: 0 enter algorithm, 1 enter overlay, 2 exit overlay, 3 algorithm done, 4 suspend, 5 resume, 6 reset, 7 overlay program. Each valid command gives exactly one of `cmd_accept` or `cmd_reject`, high for one cycle. `prog_fail` is high only together with `cmd_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or hardware) |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 3 | Command code (see R11) |
| cmd_bank | input | BANK_W | Target bank |
| cmd_sector | input | SECT_W | Sector within the bank (overlay enter and program) |
| cmd_offset | input | OFS_W | Offset within the overlay region (overlay program) |
| rd_valid | input | 1 | Host read strobe |
| rd_bank | input | BANK_W | Bank of the read |
| rd_sector | input | SECT_W | Sector of the read |
| rd_status | input | 1 | Read is a status-register read |
| cmd_accept | output | 1 | Command accepted (one-cycle pulse) |
| cmd_reject | output | 1 | Command rejected (one-cycle pulse) |
| prog_fail | output | 1 | Overlay program hit the read-only area |
| rd_class_valid | output | 1 | Read classification valid |
| rd_class | output | 2 | 00 array, 01 status, 10 overlay, 11 unavailable |
| bank_mode_o | output | 2*NUM_BANKS | Packed per-bank modes |
| susp_o | output | 1 | An algorithm is suspended |

## Verification
Every result is registered, so a command sampled at one rising edge shows its accept or reject pulse, its `prog_fail` and its new bank modes just after that same edge, which is one cycle after it is presented. A read classification also comes one cycle after its strobe, and it uses the modes as they stood when the strobe was sampled. The bench drives each request on a falling edge and holds it across one rising edge. It removes the request on the next falling edge and checks the outputs there. This always samples the one cycle in which the pulses are high.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

    typedef enum logic [1:0] {
        MODE_READ = 2'b00,
        MODE_BUSY = 2'b01,
        MODE_OVL  = 2'b10
    } bank_mode_e;

    typedef enum logic [2:0] {
        OP_ALG_ENTER = 3'd0,
        OP_OVL_ENTER = 3'd1,
        OP_OVL_EXIT  = 3'd2,
        OP_ALG_DONE  = 3'd3,
        OP_SUSPEND   = 3'd4,
        OP_RESUME    = 3'd5,
        OP_RESET     = 3'd6,
        OP_OVL_PROG  = 3'd7
    } cmd_op_e;

    typedef enum logic [1:0] {
        CLS_ARRAY  = 2'b00,
        CLS_STATUS = 2'b01,
        CLS_OVL    = 2'b10,
        CLS_NONE   = 2'b11
    } rd_class_e;

endpackage

// File: rtl/bank_cmd_eval.sv
module bank_cmd_eval
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 4,
    parameter int OFS_W     = 6,
    parameter int RO_LIMIT  = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        cmd_valid,
    input  logic [2:0]                  cmd_op,
    input  logic [BANK_W-1:0]           cmd_bank,
    input  logic [SECT_W-1:0]           cmd_sector,
    input  logic [OFS_W-1:0]            cmd_offset,
    input  logic [NUM_BANKS-1:0][1:0]   mode_q,
    input  logic                        susp_q,
    input  logic [BANK_W-1:0]           susp_bank_q,
    input  logic                        ovl_prog_q,
    input  logic [SECT_W-1:0]           ovl_sect_q,
    output logic [NUM_BANKS-1:0][1:0]   mode_d,
    output logic                        susp_d,
    output logic [BANK_W-1:0]           susp_bank_d,
    output logic                        ovl_prog_d,
    output logic [SECT_W-1:0]           ovl_sect_d,
    output logic                        acc_d,
    output logic                        rej_d,
    output logic                        fail_d
);

    logic [NUM_BANKS-1:0] bank_idle;
    logic                 all_idle;
    logic                 bank_ok;
    logic                 in_ro_area;
    logic [1:0]           cur_mode;

    // One idle flag per bank; the device is free only when all are idle.
    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_idle
        assign bank_idle[gi] = (mode_q[gi] == MODE_READ);
    end

    assign all_idle   = &bank_idle;
    assign bank_ok    = ({1'b0, cmd_bank} < (BANK_W + 1)'(NUM_BANKS));
    assign cur_mode   = bank_ok ? mode_q[cmd_bank] : MODE_READ;
    assign in_ro_area = ({1'b0, cmd_offset} < (OFS_W + 1)'(RO_LIMIT));

    always_comb begin
        mode_d      = mode_q;
        susp_d      = susp_q;
        susp_bank_d = susp_bank_q;
        ovl_prog_d  = ovl_prog_q;
        ovl_sect_d  = ovl_sect_q;
        acc_d       = 1'b0;
        rej_d       = 1'b0;
        fail_d      = 1'b0;
        if (cmd_valid) begin
            if (!bank_ok && cmd_op_e'(cmd_op) != OP_RESET) begin
                rej_d = 1'b1;
            end else begin
                case (cmd_op_e'(cmd_op))
                    OP_ALG_ENTER: begin
                        if (all_idle && !susp_q) begin
                            mode_d[cmd_bank] = MODE_BUSY;
                            ovl_prog_d       = 1'b0;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_OVL_ENTER: begin
                        if (all_idle) begin
                            mode_d[cmd_bank] = MODE_OVL;
                            ovl_sect_d       = cmd_sector;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_OVL_EXIT: begin
                        if (cur_mode == MODE_OVL) begin
                            mode_d[cmd_bank] = MODE_READ;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_ALG_DONE: begin
                        if (cur_mode == MODE_BUSY) begin
                            mode_d[cmd_bank] = ovl_prog_q ? MODE_OVL : MODE_READ;
                            ovl_prog_d       = 1'b0;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_SUSPEND: begin
                        if (cur_mode == MODE_BUSY && !ovl_prog_q) begin
                            mode_d[cmd_bank] = MODE_READ;
                            susp_d           = 1'b1;
                            susp_bank_d      = cmd_bank;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_RESUME: begin
                        if (susp_q && susp_bank_q == cmd_bank && all_idle) begin
                            mode_d[cmd_bank] = MODE_BUSY;
                            susp_d           = 1'b0;
                            acc_d            = 1'b1;
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    OP_RESET: begin
                        mode_d     = '0;
                        susp_d     = 1'b0;
                        ovl_prog_d = 1'b0;
                        acc_d      = 1'b1;
                    end
                    OP_OVL_PROG: begin
                        if (cur_mode == MODE_OVL && cmd_sector == ovl_sect_q) begin
                            if (in_ro_area) begin
                                rej_d  = 1'b1;
                                fail_d = 1'b1;
                            end else begin
                                mode_d[cmd_bank] = MODE_BUSY;
                                ovl_prog_d       = 1'b1;
                                acc_d            = 1'b1;
                            end
                        end else begin
                            rej_d = 1'b1;
                        end
                    end
                    default: rej_d = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/bank_read_class.sv
module bank_read_class
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic [BANK_W-1:0]           rd_bank,
    input  logic [SECT_W-1:0]           rd_sector,
    input  logic                        rd_status,
    input  logic [NUM_BANKS-1:0][1:0]   mode_q,
    input  logic [SECT_W-1:0]           ovl_sect_q,
    output logic [1:0]                  cls
);

    logic       bank_ok;
    logic [1:0] tgt_mode;

    assign bank_ok  = ({1'b0, rd_bank} < (BANK_W + 1)'(NUM_BANKS));
    assign tgt_mode = bank_ok ? mode_q[rd_bank] : MODE_READ;

    always_comb begin
        case (bank_mode_e'(tgt_mode))
            MODE_BUSY: cls = rd_status ? CLS_STATUS : CLS_NONE;
            MODE_OVL:  cls = (rd_sector == ovl_sect_q) ? CLS_OVL : CLS_ARRAY;
            default:   cls = CLS_ARRAY;
        endcase
        if (!bank_ok) begin
            cls = CLS_NONE;
        end
    end

endmodule

// File: rtl/bank_mode_arbiter.sv
module bank_mode_arbiter
    import bank_arb_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int SECT_W    = 4,
    parameter int OFS_W     = 6,
    parameter int RO_LIMIT  = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [2:0]               cmd_op,
    input  logic [BANK_W-1:0]        cmd_bank,
    input  logic [SECT_W-1:0]        cmd_sector,
    input  logic [OFS_W-1:0]         cmd_offset,
    input  logic                     rd_valid,
    input  logic [BANK_W-1:0]        rd_bank,
    input  logic [SECT_W-1:0]        rd_sector,
    input  logic                     rd_status,
    output logic                     cmd_accept,
    output logic                     cmd_reject,
    output logic                     prog_fail,
    output logic                     rd_class_valid,
    output logic [1:0]               rd_class,
    output logic [2*NUM_BANKS-1:0]   bank_mode_o,
    output logic                     susp_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][1:0] mode;
        logic [SECT_W-1:0]         ovl_sect;
        logic                      susp;
        logic [BANK_W-1:0]         susp_bank;
        logic                      ovl_prog;
        logic                      acc;
        logic                      rej;
        logic                      fail;
        logic                      cls_v;
        logic [1:0]                cls;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [NUM_BANKS-1:0][1:0] mode_nx;
    logic [SECT_W-1:0]         ovl_sect_nx;
    logic                      susp_nx;
    logic [BANK_W-1:0]         susp_bank_nx;
    logic                      ovl_prog_nx;
    logic                      acc_nx, rej_nx, fail_nx;
    logic [1:0]                cls_nx;

    bank_cmd_eval #(
        .NUM_BANKS (NUM_BANKS),
        .SECT_W    (SECT_W),
        .OFS_W     (OFS_W),
        .RO_LIMIT  (RO_LIMIT)
    ) cmd_eval_i (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_bank    (cmd_bank),
        .cmd_sector  (cmd_sector),
        .cmd_offset  (cmd_offset),
        .mode_q      (state_q.mode),
        .susp_q      (state_q.susp),
        .susp_bank_q (state_q.susp_bank),
        .ovl_prog_q  (state_q.ovl_prog),
        .ovl_sect_q  (state_q.ovl_sect),
        .mode_d      (mode_nx),
        .susp_d      (susp_nx),
        .susp_bank_d (susp_bank_nx),
        .ovl_prog_d  (ovl_prog_nx),
        .ovl_sect_d  (ovl_sect_nx),
        .acc_d       (acc_nx),
        .rej_d       (rej_nx),
        .fail_d      (fail_nx)
    );

    bank_read_class #(
        .NUM_BANKS (NUM_BANKS),
        .SECT_W    (SECT_W)
    ) read_class_i (
        .rd_bank    (rd_bank),
        .rd_sector  (rd_sector),
        .rd_status  (rd_status),
        .mode_q     (state_q.mode),
        .ovl_sect_q (state_q.ovl_sect),
        .cls        (cls_nx)
    );

    always_comb begin
        state_d           = state_q;
        state_d.mode      = mode_nx;
        state_d.ovl_sect  = ovl_sect_nx;
        state_d.susp      = susp_nx;
        state_d.susp_bank = susp_bank_nx;
        state_d.ovl_prog  = ovl_prog_nx;
        state_d.acc       = acc_nx;
        state_d.rej       = rej_nx;
        state_d.fail      = fail_nx;
        state_d.cls_v     = rd_valid;
        state_d.cls       = rd_valid ? cls_nx : CLS_ARRAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmd_accept     = state_q.acc;
    assign cmd_reject     = state_q.rej;
    assign prog_fail      = state_q.fail;
    assign rd_class_valid = state_q.cls_v;
    assign rd_class       = state_q.cls;
    assign bank_mode_o    = state_q.mode;
    assign susp_o         = state_q.susp;

endmodule

// File: rtl/bank_mode_arbiter_chk.sv
module bank_mode_arbiter_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_op,
    input logic                   cmd_accept,
    input logic                   cmd_reject,
    input logic                   prog_fail,
    input logic                   rd_valid,
    input logic                   rd_class_valid,
    input logic [2*NUM_BANKS-1:0] bank_mode_o
);

    logic [NUM_BANKS-1:0] busy_vec;
    for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_busy
        assign busy_vec[gi] = (bank_mode_o[2*gi +: 2] != 2'b00);
    end

    // R2: one non-read bank at most
    a_r2_single_active: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_vec));

    // R3: a rejected command leaves all modes unchanged
    a_r3_reject_holds_modes: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $stable(bank_mode_o));

    // R4: reset command clears every bank
    a_r4_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd6) |=> (bank_mode_o == '0 && cmd_accept));

    // R9: failed overlay program is a rejection
    a_r9_fail_with_reject: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fail |-> cmd_reject);

    // R11: accept and reject never together, and each follows a command
    a_r11_acc_rej_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    a_r11_resp_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (cmd_accept || cmd_reject));

    // R6: classification appears one cycle after a read strobe
    a_r6_class_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_class_valid);

endmodule

bind bank_mode_arbiter bank_mode_arbiter_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .cmd_accept     (cmd_accept),
    .cmd_reject     (cmd_reject),
    .prog_fail      (prog_fail),
    .rd_valid       (rd_valid),
    .rd_class_valid (rd_class_valid),
    .bank_mode_o    (bank_mode_o)
);

// File: tb/bank_mode_arbiter_tb_top.sv
`timescale 1ns/1ps
module bank_mode_arbiter_tb_top;

    localparam int NB     = 4;
    localparam int BW     = 2;
    localparam int SW     = 4;
    localparam int OW     = 6;
    localparam int RO_LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [BW-1:0] cmd_bank = '0;
    logic [SW-1:0] cmd_sector = '0;
    logic [OW-1:0] cmd_offset = '0;
    logic          rd_valid = 1'b0;
    logic [BW-1:0] rd_bank = '0;
    logic [SW-1:0] rd_sector = '0;
    logic          rd_status = 1'b0;
    logic          cmd_accept, cmd_reject, prog_fail, rd_class_valid, susp_o;
    logic [1:0]    rd_class;
    logic [2*NB-1:0] bank_mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bank_mode_arbiter #(
        .NUM_BANKS (NB), .SECT_W (SW), .OFS_W (OW), .RO_LIMIT (RO_LIM)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
        .cmd_sector (cmd_sector), .cmd_offset (cmd_offset),
        .rd_valid (rd_valid), .rd_bank (rd_bank), .rd_sector (rd_sector),
        .rd_status (rd_status),
        .cmd_accept (cmd_accept), .cmd_reject (cmd_reject), .prog_fail (prog_fail),
        .rd_class_valid (rd_class_valid), .rd_class (rd_class),
        .bank_mode_o (bank_mode_o), .susp_o (susp_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mv(input int b, input int m);
        return m << (2 * b);
    endfunction

    // Issue one command; returns with outputs of that command visible.
    task automatic do_cmd(input int op, input int b, input int sec, input int ofs);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = 3'(op);
        cmd_bank   = BW'(b);
        cmd_sector = SW'(sec);
        cmd_offset = OW'(ofs);
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    task automatic cmd_chk(input string tag, input int op, input int b, input int sec,
                           input int ofs, input int exp_acc, input int exp_modes);
        do_cmd(op, b, sec, ofs);
        check({tag, " accept"}, int'(cmd_accept), exp_acc);
        check({tag, " reject"}, int'(cmd_reject), 1 - exp_acc);
        check({tag, " modes"}, int'(bank_mode_o), exp_modes);
    endtask

    task automatic rd_chk(input string tag, input int b, input int sec, input int st, input int exp_cls);
        @(negedge clk);
        rd_valid  = 1'b1;
        rd_bank   = BW'(b);
        rd_sector = SW'(sec);
        rd_status = st[0];
        @(negedge clk);
        rd_valid  = 1'b0;
        check({tag, " cls_valid"}, int'(rd_class_valid), 1);
        check({tag, " class"}, int'(rd_class), exp_cls);
    endtask

    task automatic t_reset_state();
        check("R1 modes after reset", int'(bank_mode_o), 0);
        check("R1 susp after reset", int'(susp_o), 0);
        check("R1 accept after reset", int'(cmd_accept), 0);
        check("R1 reject after reset", int'(cmd_reject), 0);
        rd_chk("R7 idle read", 2, 3, 0, 0);
    endtask

    task automatic t_alg_srw();
        cmd_chk("R11 enter alg b1", 0, 1, 0, 0, 1, mv(1, 1));
        rd_chk("R6 busy array read", 1, 0, 0, 3);
        rd_chk("R6 busy status read", 1, 0, 1, 1);
        rd_chk("R7 other bank read", 2, 0, 0, 0);
        cmd_chk("R3 enter ovl b2 while busy", 1, 2, 5, 0, 0, mv(1, 1));
        cmd_chk("R3 enter alg b3 while busy", 0, 3, 0, 0, 0, mv(1, 1));
        cmd_chk("R3 enter alg same bank", 0, 1, 0, 0, 0, mv(1, 1));
        cmd_chk("R5 done wrong bank", 3, 0, 0, 0, 0, mv(1, 1));
        cmd_chk("R5 done b1", 3, 1, 0, 0, 1, 0);
        cmd_chk("R5 done when idle", 3, 1, 0, 0, 0, 0);
    endtask

    task automatic t_overlay();
        cmd_chk("R8 enter ovl b2 s5", 1, 2, 5, 0, 1, mv(2, 2));
        rd_chk("R8 ovl sector read", 2, 5, 0, 2);
        rd_chk("R7 ovl bank other sector", 2, 4, 0, 0);
        rd_chk("R7 other bank during ovl", 0, 5, 0, 0);
        cmd_chk("R3 enter alg during ovl", 0, 0, 0, 0, 0, mv(2, 2));
        do_cmd(7, 2, 5, 3);
        check("R9 ro prog reject", int'(cmd_reject), 1);
        check("R9 ro prog fail", int'(prog_fail), 1);
        check("R9 ro prog modes", int'(bank_mode_o), mv(2, 2));
        cmd_chk("R9 prog wrong sector", 7, 2, 4, 20, 0, mv(2, 2));
        check("R9 no fail on wrong sector", int'(prog_fail), 0);
        cmd_chk("R9 prog boundary ofs", 7, 2, 5, RO_LIM, 1, mv(2, 1));
        check("R9 no fail on good prog", int'(prog_fail), 0);
        rd_chk("R6 ovl prog busy read", 2, 5, 0, 3);
        cmd_chk("R10 suspend ovl prog", 4, 2, 0, 0, 0, mv(2, 1));
        cmd_chk("R5 done ovl prog", 3, 2, 0, 0, 1, mv(2, 2));
        cmd_chk("R8 exit ovl", 2, 2, 0, 0, 1, 0);
        cmd_chk("R8 exit when idle", 2, 2, 0, 0, 0, 0);
    endtask

    task automatic t_suspend();
        cmd_chk("R10 enter alg b1", 0, 1, 0, 0, 1, mv(1, 1));
        cmd_chk("R10 suspend b1", 4, 1, 0, 0, 1, 0);
        check("R10 susp set", int'(susp_o), 1);
        rd_chk("R7 suspended bank read", 1, 0, 0, 0);
        cmd_chk("R3 enter alg while suspended", 0, 0, 0, 0, 0, 0);
        cmd_chk("R10 ovl while suspended", 1, 3, 2, 0, 1, mv(3, 2));
        cmd_chk("R10 resume during ovl", 5, 1, 0, 0, 0, mv(3, 2));
        cmd_chk("R10 exit ovl b3", 2, 3, 0, 0, 1, 0);
        cmd_chk("R10 resume wrong bank", 5, 0, 0, 0, 0, 0);
        cmd_chk("R10 resume b1", 5, 1, 0, 0, 1, mv(1, 1));
        check("R10 susp cleared", int'(susp_o), 0);
        cmd_chk("R10 done b1", 3, 1, 0, 0, 1, 0);
    endtask

    task automatic t_reset_cmd();
        cmd_chk("R4 setup alg b3", 0, 3, 0, 0, 1, mv(3, 1));
        cmd_chk("R4 suspend b3", 4, 3, 0, 0, 1, 0);
        cmd_chk("R4 setup ovl b0", 1, 0, 1, 0, 1, mv(0, 2));
        cmd_chk("R4 reset cmd", 6, 2, 0, 0, 1, 0);
        check("R4 susp cleared", int'(susp_o), 0);
        cmd_chk("R4 alg after reset", 0, 0, 0, 0, 1, mv(0, 1));
        cmd_chk("R4 reset again", 6, 0, 0, 0, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_alg_srw();
        t_overlay();
        t_suspend();
        t_reset_cmd();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule